// File: doc/BRIEF.md
# Window-Regulated PWM/PFM Switching Controller

This block is the digital core of an inductor-based DC/DC converter. It sequences the gate enables of the main power switch and the synchronous rectifier from a fast timebase. A nominal 13 MHz timebase, or an external sync clock between 9 and 20 MHz, serves as `clk`. The period is 22 timebase cycles, which gives about 590 kHz at 13 MHz. Regulation is hysteretic rather than error-amplifier based. Two comparator flags report whether the output voltage lies below the low limit or above the high limit of a voltage window. While the output stays inside the window, the same switching pattern repeats every period.

The decision for the next period is taken at the last slot of each period, at the end of the ramp-down. A low-window crossing lengthens the on-time by a large step so the inductor DC current steps up. A high-window crossing shortens it by a small step. Under light load the inductor current reaches zero in every period. In that case the controller falls back to discontinuous (PFM) operation. In PFM it fires a pulse slightly longer than the learned on-time and skips periods while the output sits above the high limit. It returns to PWM as soon as the output drops below the low limit. A current-limit flag and a zero-current flag cut the conduction phases short. Shutdown and undervoltage lockout stop everything within one clock.

Top module: `win_reg_ctrl`

## Requirements
- R1: While `rst` is high, both gate outputs and `pfm_mode` are 0 and the on-time is the minimum of 2 slots. The first period after release drives `gate_main` for exactly slots 0 and 1.
- R2: The period is 22 timebase cycles (slots 0..21). With no flag asserted, the main gate is wanted in slots below the on-time and the rectifier in the remaining slots. The pattern repeats unchanged every period.
- R3: Only the flags present at slot 21 steer the on-time. `v_below` adds 6 slots, taking priority. Otherwise `v_above` subtracts 2 slots, with a floor of 2. The new value applies from the next slot 0. Outside slot 21 the window flags leave the on-time unchanged.
- R4: The on-time ceiling is 20 slots when `up_mode`=1 (step-up) and 22 slots when `up_mode`=0 (step-down). At 22, `gate_main` stays high for the whole period with no rectifier pulse (100% duty).
- R5: `gate_main` and `gate_rect` are never high together. Either gate turns on only after a cycle in which the other was low.
- R6: When `i_limit` is high while `gate_main` is high, `gate_main` is low from the next cycle until the period ends, and the rectifier takes over one cycle later.
- R7: When `i_zero` is high during the off part of a period, `gate_rect` is low from the next cycle until the period ends.
- R8: After 4 consecutive PWM periods in each of which `i_zero` fired during the off part, `pfm_mode` (1 = PFM) rises at the following slot 0. Three such periods are not enough.
- R9: In PFM, the on-time is the learned value plus 1, clamped to the ceiling. The on-time is frozen. If `v_above` is high at slot 21, the next period drives neither gate. If `v_below` is high at slot 21, the controller returns to PWM with the frozen on-time.
- R10: A cycle with `shdn` or `uvlo` high forces both gates and `pfm_mode` to 0 on the next edge. It also returns the period counter to slot 0 and the on-time to its minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (internal oscillator or external sync) |
| rst | input | 1 | Synchronous active-high reset |
| up_mode | input | 1 | 1 = step-up conversion, 0 = step-down conversion |
| shdn | input | 1 | Shutdown request, active high |
| uvlo | input | 1 | Undervoltage lockout, active high |
| v_below | input | 1 | Output is below the window low limit |
| v_above | input | 1 | Output is above the window high limit |
| i_zero | input | 1 | Inductor current has reached zero |
| i_limit | input | 1 | Inductor current has reached the limit |
| gate_main | output | 1 | Enable for the main power switch |
| gate_rect | output | 1 | Enable for the synchronous rectifier |
| pfm_mode | output | 1 | 1 = discontinuous (PFM) operation, 0 = PWM |

## Verification
The hardest state to reach from the ports is PFM with a skipped period. Getting there takes four whole periods with the zero-current flag present in the off part, then the high-limit flag held across a period boundary. Return to PWM then needs the low-limit flag at the last slot of a skipped period. The bench holds `i_zero` steady from a known slot-0 alignment after a shutdown. It then walks the window flags period by period, while a behavioural model predicts every gate and mode value on every clock. The 100% duty case is reached the same way: the low-limit flag is held over successive boundaries in step-down mode until the on-time meets the full period.

// File: rtl/win_reg_pkg.sv
package win_reg_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/win_period_timer.sv
module win_period_timer #(
  parameter int PERIOD = 22,
  localparam int TW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  output logic [TW-1:0] slot,
  output logic          last
);
  assign last = (slot == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || halt)  slot <= '0;
    else if (last)    slot <= '0;
    else              slot <= slot + 1'b1;
  end
endmodule

// File: rtl/win_ton_reg.sv
module win_ton_reg
  import win_reg_pkg::*;
#(
  parameter int PERIOD    = 22,
  parameter int TON_MIN   = 2,
  parameter int UP_STEP   = 6,
  parameter int DN_STEP   = 2,
  parameter int PFM_EXTRA = 1,
  localparam int TW = $clog2(PERIOD + 1),
  localparam int SW = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          last,
  input  logic          pfm,
  input  logic          up_mode,
  input  logic          below,
  input  logic          above,
  output logic [TW-1:0] ton_eff
);
  logic [TW-1:0] ton_q, ton_d;
  logic [SW-1:0] tmax, raised, lowered, held, pfm_w, pick;
  step_e         step;

  always_comb begin
    tmax    = up_mode ? SW'(PERIOD - 2) : SW'(PERIOD);
    raised  = SW'(ton_q) + SW'(UP_STEP);
    lowered = (SW'(ton_q) >= SW'(TON_MIN + DN_STEP)) ? SW'(ton_q) - SW'(DN_STEP)
                                                     : SW'(TON_MIN);
    held    = SW'(ton_q);
    pfm_w   = SW'(ton_q) + SW'(PFM_EXTRA);
    if (below)      step = STEP_UP;
    else if (above) step = STEP_DOWN;
    else            step = STEP_HOLD;
    case (step)
      STEP_UP:   pick = raised;
      STEP_DOWN: pick = lowered;
      default:   pick = held;
    endcase
    ton_d = (pick > tmax) ? tmax[TW-1:0] : pick[TW-1:0];
    if (pfm) ton_eff = (pfm_w > tmax) ? tmax[TW-1:0] : pfm_w[TW-1:0];
    else     ton_eff = ton_q;
  end

  always_ff @(posedge clk) begin
    if (rst || halt)       ton_q <= TW'(TON_MIN);
    else if (last && !pfm) ton_q <= ton_d;
  end
endmodule

// File: rtl/win_mode_fsm.sv
module win_mode_fsm #(
  parameter int PFM_ENTRY = 4,
  localparam int ZW = $clog2(PFM_ENTRY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic last,
  input  logic below,
  input  logic above,
  input  logic zcyc,
  output logic pfm,
  output logic skip
);
  logic [ZW-1:0] zrun;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      pfm  <= 1'b0;
      skip <= 1'b0;
      zrun <= '0;
    end else if (last) begin
      if (!pfm) begin
        skip <= 1'b0;
        if (!zcyc) begin
          zrun <= '0;
        end else if (zrun == ZW'(PFM_ENTRY - 1)) begin
          zrun <= '0;
          pfm  <= 1'b1;
        end else begin
          zrun <= zrun + 1'b1;
        end
      end else begin
        zrun <= '0;
        if (below) begin
          pfm  <= 1'b0;
          skip <= 1'b0;
        end else begin
          skip <= above;
        end
      end
    end
  end
endmodule

// File: rtl/win_gate_drv.sv
module win_gate_drv #(
  parameter int PERIOD = 22,
  localparam int TW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          last,
  input  logic [TW-1:0] slot,
  input  logic [TW-1:0] ton_eff,
  input  logic          skip,
  input  logic          i_zero,
  input  logic          i_limit,
  output logic          gate_main,
  output logic          gate_rect,
  output logic          zcyc
);
  logic lim_q, zseen_q;
  logic off_part, want_main, want_rect;

  always_comb begin
    off_part  = (slot >= ton_eff) || lim_q;
    want_main = !skip && (slot < ton_eff) && !lim_q && !i_limit;
    want_rect = !skip && off_part && !zseen_q && !i_zero;
    zcyc      = zseen_q || (i_zero && off_part);
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      gate_main <= 1'b0;
      gate_rect <= 1'b0;
      lim_q     <= 1'b0;
      zseen_q   <= 1'b0;
    end else begin
      gate_main <= want_main && !gate_rect;
      gate_rect <= want_rect && !gate_main;
      lim_q     <= last ? 1'b0 : (lim_q || (i_limit && gate_main));
      zseen_q   <= last ? 1'b0 : zcyc;
    end
  end
endmodule

// File: rtl/win_reg_ctrl.sv
module win_reg_ctrl #(
  parameter int PERIOD    = 22,
  parameter int TON_MIN   = 2,
  parameter int UP_STEP   = 6,
  parameter int DN_STEP   = 2,
  parameter int PFM_EXTRA = 1,
  parameter int PFM_ENTRY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic up_mode,
  input  logic shdn,
  input  logic uvlo,
  input  logic v_below,
  input  logic v_above,
  input  logic i_zero,
  input  logic i_limit,
  output logic gate_main,
  output logic gate_rect,
  output logic pfm_mode
);
  localparam int TW = $clog2(PERIOD + 1);

  logic          halt, last, pfm, skip, zcyc;
  logic [TW-1:0] slot, ton_eff;

  assign halt     = shdn | uvlo;
  assign pfm_mode = pfm;

  win_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .halt(halt), .slot(slot), .last(last)
  );

  win_ton_reg #(
    .PERIOD(PERIOD), .TON_MIN(TON_MIN), .UP_STEP(UP_STEP),
    .DN_STEP(DN_STEP), .PFM_EXTRA(PFM_EXTRA)
  ) u_ton (
    .clk(clk), .rst(rst), .halt(halt), .last(last), .pfm(pfm),
    .up_mode(up_mode), .below(v_below), .above(v_above), .ton_eff(ton_eff)
  );

  win_mode_fsm #(.PFM_ENTRY(PFM_ENTRY)) u_mode (
    .clk(clk), .rst(rst), .halt(halt), .last(last), .below(v_below),
    .above(v_above), .zcyc(zcyc), .pfm(pfm), .skip(skip)
  );

  win_gate_drv #(.PERIOD(PERIOD)) u_gate (
    .clk(clk), .rst(rst), .halt(halt), .last(last), .slot(slot),
    .ton_eff(ton_eff), .skip(skip), .i_zero(i_zero), .i_limit(i_limit),
    .gate_main(gate_main), .gate_rect(gate_rect), .zcyc(zcyc)
  );
endmodule

// File: rtl/win_reg_ctrl_chk.sv
module win_reg_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic shdn,
  input logic uvlo,
  input logic i_zero,
  input logic i_limit,
  input logic gate_main,
  input logic gate_rect,
  input logic pfm_mode
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_main && gate_rect));

  // R5
  dead_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_main) |-> !$past(gate_rect));

  // R6
  limit_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_main && i_limit) |=> !gate_main);

  // R7
  zero_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_rect && i_zero) |=> !gate_rect);

  // R10
  halt_off_chk: assert property (@(posedge clk) disable iff (rst)
    (shdn || uvlo) |=> (!gate_main && !gate_rect && !pfm_mode));
endmodule

bind win_reg_ctrl win_reg_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .shdn(shdn), .uvlo(uvlo), .i_zero(i_zero),
  .i_limit(i_limit), .gate_main(gate_main), .gate_rect(gate_rect),
  .pfm_mode(pfm_mode)
);

// File: tb/tb_win_reg_ctrl.sv
`timescale 1ns/1ps
module tb_win_reg_ctrl;
  localparam int P = 22, TMIN = 2, UPS = 6, DNS = 2, ENTRY = 4, EXTRA = 1;

  logic clk = 1'b0;
  logic rst, up_mode, shdn, uvlo, v_below, v_above, i_zero, i_limit;
  logic gate_main, gate_rect, pfm_mode;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  int m_slot, m_ton, m_pfm, m_zrun, m_lim, m_zseen, m_skip, m_gm, m_gr;

  always #2 clk = ~clk;

  win_reg_ctrl dut (
    .clk(clk), .rst(rst), .up_mode(up_mode), .shdn(shdn), .uvlo(uvlo),
    .v_below(v_below), .v_above(v_above), .i_zero(i_zero), .i_limit(i_limit),
    .gate_main(gate_main), .gate_rect(gate_rect), .pfm_mode(pfm_mode)
  );

  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  task automatic model_step();
    int tmax, teff, off, wm, wr, zc, eop;
    int n_slot, n_ton, n_pfm, n_zrun, n_lim, n_zseen, n_skip, n_gm, n_gr;
    if (rst || shdn || uvlo) begin
      m_slot = 0; m_ton = TMIN; m_pfm = 0; m_zrun = 0; m_lim = 0;
      m_zseen = 0; m_skip = 0; m_gm = 0; m_gr = 0;
      return;
    end
    eop  = (m_slot == P - 1);
    tmax = up_mode ? P - 2 : P;
    teff = m_pfm ? imin(m_ton + EXTRA, tmax) : m_ton;
    off  = (m_slot >= teff) || m_lim;
    wm   = !m_skip && (m_slot < teff) && !m_lim && !i_limit;
    wr   = !m_skip && off && !m_zseen && !i_zero;
    zc   = m_zseen || (i_zero && off);
    n_gm = wm && !m_gr;
    n_gr = wr && !m_gm;
    n_lim = eop ? 0 : (m_lim || (i_limit && m_gm));
    n_zseen = eop ? 0 : zc;
    n_slot = eop ? 0 : m_slot + 1;
    n_ton = m_ton; n_pfm = m_pfm; n_zrun = m_zrun; n_skip = m_skip;
    if (eop) begin
      if (!m_pfm) begin
        n_skip = 0;
        if (v_below)      n_ton = imin(m_ton + UPS, tmax);
        else if (v_above) n_ton = imin(imax(m_ton - DNS, TMIN), tmax);
        else              n_ton = imin(m_ton, tmax);
        if (zc) begin
          n_zrun = m_zrun + 1;
          if (n_zrun == ENTRY) begin n_pfm = 1; n_zrun = 0; end
        end else n_zrun = 0;
      end else begin
        n_zrun = 0;
        if (v_below) begin n_pfm = 0; n_skip = 0; end
        else n_skip = v_above;
      end
    end
    m_slot = n_slot; m_ton = n_ton; m_pfm = n_pfm; m_zrun = n_zrun; m_lim = n_lim;
    m_zseen = n_zseen; m_skip = n_skip; m_gm = n_gm; m_gr = n_gr;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    checks++;
    if (gate_main !== m_gm[0] || gate_rect !== m_gr[0] || pfm_mode !== m_pfm[0]) begin
      failures++;
      $display("FAIL %s model mismatch cycle %0d: actual gm=%b gr=%b pfm=%b expected gm=%0d gr=%0d pfm=%0d",
               cur_req, cyc, gate_main, gate_rect, pfm_mode, m_gm, m_gr, m_pfm);
    end
    // R5: no overlap on any clock
    check("R5", "gate overlap", int'(gate_main && gate_rect), 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run_period(output int mh, output int rh);
    mh = 0; rh = 0;
    for (int s = 0; s < P; s++) begin
      tick();
      mh += int'(gate_main);
      rh += int'(gate_rect);
    end
  endtask

  initial begin
    int guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mh, rh;
    rst = 1; up_mode = 1; shdn = 0; uvlo = 0;
    v_below = 0; v_above = 0; i_zero = 0; i_limit = 0;
    m_slot = 0; m_ton = TMIN; m_pfm = 0; m_zrun = 0; m_lim = 0;
    m_zseen = 0; m_skip = 0; m_gm = 0; m_gr = 0;
    repeat (3) tick();
    // R1 reset state
    check("R1", "gate_main in reset", int'(gate_main), 0);
    check("R1", "gate_rect in reset", int'(gate_rect), 0);
    check("R1", "pfm_mode in reset", int'(pfm_mode), 0);
    rst = 0;
    run_period(mh, rh);
    check("R1", "first period main slots", mh, 2);
    check("R1", "first period rect slots", rh, 19);

    cur_req = "R2";
    run_period(mh, rh);
    check("R2", "steady main slots", mh, 1);
    check("R2", "steady rect slots", rh, 19);
    run_period(mh, rh);
    check("R2", "repeat main slots", mh, 1);

    cur_req = "R3";
    v_below = 1;
    run_period(mh, rh);
    v_below = 0;
    run_period(mh, rh);
    check("R3", "main slots after raise", mh, 7);
    v_above = 1;
    repeat (3) run_period(mh, rh);
    v_above = 0;
    run_period(mh, rh);
    check("R3", "main slots after lowering", mh, 1);
    v_above = 1;
    run_period(mh, rh);
    v_above = 0;
    run_period(mh, rh);
    check("R3", "floor holds at minimum", mh, 1);
    // window flags away from slot 21 must not move the on-time
    for (int s = 0; s < P; s++) begin
      v_below = (s == 5);
      tick();
    end
    v_below = 0;
    run_period(mh, rh);
    check("R3", "mid-period flag ignored", mh, 1);

    cur_req = "R7";
    for (int s = 0; s < P; s++) begin
      i_zero = (s == 10);
      tick();
      if (s == 10) check("R7", "rect off after zero", int'(gate_rect), 0);
      if (s == 15) check("R7", "rect stays off", int'(gate_rect), 0);
    end
    i_zero = 0;

    cur_req = "R4";
    v_below = 1;
    repeat (4) run_period(mh, rh);
    v_below = 0;
    run_period(mh, rh);
    check("R4", "step-up ceiling main slots", mh, 19);
    check("R4", "step-up ceiling rect slots", rh, 1);
    up_mode = 0; v_below = 1;
    run_period(mh, rh);
    v_below = 0;
    run_period(mh, rh);
    run_period(mh, rh);
    check("R4", "full duty main slots", mh, 22);
    check("R4", "full duty rect slots", rh, 0);

    cur_req = "R6";
    for (int s = 0; s < P; s++) begin
      i_limit = (s == 5);
      tick();
      if (s == 5)  check("R6", "main off after limit", int'(gate_main), 0);
      if (s == 10) check("R6", "rect took over", int'(gate_rect), 1);
      if (s == 21) check("R6", "main stays off", int'(gate_main), 0);
    end
    i_limit = 0;

    cur_req = "R10";
    shdn = 1;
    tick();
    check("R10", "main off after shdn", int'(gate_main), 0);
    check("R10", "rect off after shdn", int'(gate_rect), 0);
    shdn = 0; uvlo = 1;
    tick();
    check("R10", "main off under uvlo", int'(gate_main), 0);
    uvlo = 0;
    run_period(mh, rh);
    check("R10", "on-time reset to minimum", mh, 2);

    cur_req = "R8";
    i_zero = 1;
    repeat (3) run_period(mh, rh);
    check("R8", "pfm not yet after 3 periods", int'(pfm_mode), 0);
    run_period(mh, rh);
    check("R8", "pfm after 4 periods", int'(pfm_mode), 1);

    cur_req = "R9";
    run_period(mh, rh);
    check("R9", "pfm pulse width", mh, 3);
    v_above = 1;
    run_period(mh, rh);
    run_period(mh, rh);
    check("R9", "skipped period main", mh, 0);
    check("R9", "skipped period rect", rh, 0);
    v_above = 0; v_below = 1;
    run_period(mh, rh);
    check("R9", "back to pwm", int'(pfm_mode), 0);
    v_below = 0;
    run_period(mh, rh);
    check("R9", "on-time frozen in pfm", mh, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule